// File: doc/BRIEF.md
# Latched 4-to-16 Address Decoder

This block holds a 4-bit address in a register and turns it into a one-hot select vector with active-high lines. While the load-enable input is high, the register takes the address on every clock edge. While it is low, the register keeps its value and the address pins have no effect. An active-high blanking input overrides everything else and forces every select line low, at once, with no clock edge needed.

The same block serves three uses. The first is a plain decoder, with load-enable tied high. The second is a 1-to-16 demultiplexer: the held address picks a line, and the blanking input carries a data bit, so the picked line shows that bit inverted. The third is a 32-way page selector for a processor bus, chosen by a parameter. In that mode two decode banks share the 4 low address bits, which come from bus bits 11..8. A fifth, unlatched address bit comes from bus bit 12 and enables the lower bank when it is 0 and the upper bank when it is 1. Each of the 32 lines then covers one 256-byte page in the range 0x0000 to 0x1FFF.

Top module: `page_select_dec`

## Requirements
- R1: While rst_ni is low, the held address is zero. After reset, with le_i low and cs_i low, sel_o equals 1 (line 0 is high).
- R2: With le_i high at a rising clock edge, addr_i[3:0] is stored at that edge. Bit 3 is the most significant. After the edge, line n of sel_o is high, where n is the stored value.
- R3: With le_i low, the stored address is kept across clock edges, and changes on addr_i[3:0] do not alter sel_o.
- R4: With cs_i high, every bit of sel_o is 0 in the same cycle, whatever the values of le_i and addr_i. The stored address is still loaded while le_i is high.
- R5: With cs_i low, exactly one bit of sel_o is 1. sel_o never has more than one bit set.
- R6: Used as a demultiplexer with the address held, the selected line equals the inverse of cs_i, and all other lines stay 0.
- R7: With CASCADE=1, addr_i is 5 bits wide and sel_o is 32 bits wide. The line index is {addr_i[4], stored addr_i[3:0]}. addr_i[4] is not stored: a change on it moves the selection within the same cycle, even while le_i is low.
- R8: cs_i keeps forcing sel_o to all zeros while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the held address |
| le_i | input | 1 | Load enable: high loads the address each edge, low holds it |
| cs_i | input | 1 | Active-high blanking; the data input in demultiplexer use |
| addr_i | input | ADDR_W+CASCADE | Address; the top bit is the unlatched page bit when CASCADE=1 |
| sel_o | output | (1+CASCADE)*2**ADDR_W | One-hot active-high select lines |

## Verification
The cycle of interest is one in which cs_i is high and le_i is high with a new address. The blanking must hide the output, while the load still takes the new address at the same edge. The bench drives both inputs together, checks that sel_o is zero in that cycle, then drops cs_i with le_i low and a different address on the pins. The line that comes up must be the one loaded under blanking. A second case of the same kind changes the cascade page bit while the low address is held. The bench checks that the selection moves to the other bank in the same cycle, with no edge needed.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned LINES  = 1 << ADDR_W;
endpackage

// File: rtl/sel_addr_hold.sv
module sel_addr_hold #(
  parameter int unsigned W = sel_pkg::ADDR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sel_onehot_dec.sv
module sel_onehot_dec #(
  parameter int unsigned W = sel_pkg::ADDR_W,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] idx_i,
  input  logic         off_i,
  output logic [N-1:0] hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = !off_i && (idx_i == W'(i));
  end
endmodule

// File: rtl/page_select_dec.sv
module page_select_dec #(
  parameter int unsigned ADDR_W  = sel_pkg::ADDR_W,
  parameter bit          CASCADE = 1'b0,
  localparam int unsigned BANKS  = CASCADE ? 2 : 1,
  localparam int unsigned AW_TOP = ADDR_W + (CASCADE ? 1 : 0),
  localparam int unsigned LINES  = 1 << ADDR_W,
  localparam int unsigned OUT_W  = BANKS * LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              cs_i,
  input  logic [AW_TOP-1:0] addr_i,
  output logic [OUT_W-1:0]  sel_o
);
  logic [ADDR_W-1:0] held;
  logic [BANKS-1:0]  bank_off;

  sel_addr_hold #(.W(ADDR_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (le_i),
    .d_i    (addr_i[ADDR_W-1:0]),
    .q_o    (held)
  );

  // page bit bypasses the register and steers bank blanking directly
  if (CASCADE) begin : g_pair
    logic page;
    assign page        = addr_i[AW_TOP-1];
    assign bank_off[0] = cs_i | page;
    assign bank_off[1] = cs_i | ~page;
  end else begin : g_single
    assign bank_off[0] = cs_i;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sel_onehot_dec #(.W(ADDR_W)) u_dec (
      .idx_i (held),
      .off_i (bank_off[b]),
      .hot_o (sel_o[b*LINES +: LINES])
    );
  end
endmodule

// File: rtl/page_select_dec_chk.sv
module page_select_dec_chk #(
  parameter int unsigned ADDR_W  = sel_pkg::ADDR_W,
  parameter bit          CASCADE = 1'b0,
  localparam int unsigned BANKS  = CASCADE ? 2 : 1,
  localparam int unsigned AW_TOP = ADDR_W + (CASCADE ? 1 : 0),
  localparam int unsigned OUT_W  = BANKS * (1 << ADDR_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              le_i,
  input logic              cs_i,
  input logic [AW_TOP-1:0] addr_i,
  input logic [OUT_W-1:0]  sel_o
);
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_le;
  logic              prev_ok;
  logic [AW_TOP-1:0] exp_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr <= '0;
      prev_le   <= 1'b0;
      prev_ok   <= 1'b0;
    end else begin
      prev_addr <= addr_i[ADDR_W-1:0];
      prev_le   <= le_i;
      prev_ok   <= 1'b1;
    end
  end

  if (CASCADE) begin : g_idx_pair
    assign exp_idx = {addr_i[AW_TOP-1], prev_addr};
  end else begin : g_idx_single
    assign exp_idx = prev_addr;
  end

  p_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_ok && prev_le && !cs_i) |-> sel_o[exp_idx]);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_ok && !prev_le && !cs_i && $past(!cs_i) && $stable(addr_i[AW_TOP-1]))
      |-> $stable(sel_o));

  p_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |-> (sel_o == '0));

  p_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> ($countones(sel_o) == 1));

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
endmodule

bind page_select_dec page_select_dec_chk #(.ADDR_W(ADDR_W), .CASCADE(CASCADE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .le_i   (le_i),
  .cs_i   (cs_i),
  .addr_i (addr_i),
  .sel_o  (sel_o)
);

// File: tb/page_select_dec_test.sv
module page_select_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        le = 1'b1, cs = 1'b0;
  logic [3:0]  addr = 4'h9;
  logic [15:0] sel;
  logic        pg_le = 1'b1, pg_cs = 1'b0;
  logic [4:0]  pg_addr = 5'h00;
  logic [31:0] pg_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  page_select_dec #(.CASCADE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .le_i(le), .cs_i(cs), .addr_i(addr), .sel_o(sel));

  page_select_dec #(.CASCADE(1'b1)) uut_pg (
    .clk_i(clk), .rst_ni(rst_n), .le_i(pg_le), .cs_i(pg_cs), .addr_i(pg_addr), .sel_o(pg_sel));

  // {le, cs, addr, any_high, index}
  localparam logic [10:0] VEC [12] = '{
    {1'b1, 1'b0, 4'h5, 1'b1, 4'h5},
    {1'b1, 1'b0, 4'hF, 1'b1, 4'hF},
    {1'b0, 1'b0, 4'h3, 1'b1, 4'hF},
    {1'b0, 1'b0, 4'h9, 1'b1, 4'hF},
    {1'b0, 1'b1, 4'h9, 1'b0, 4'h0},
    {1'b1, 1'b1, 4'h6, 1'b0, 4'h0},
    {1'b0, 1'b0, 4'h0, 1'b1, 4'h6},
    {1'b1, 1'b0, 4'h0, 1'b1, 4'h0},
    {1'b1, 1'b0, 4'hA, 1'b1, 4'hA},
    {1'b0, 1'b1, 4'hA, 1'b0, 4'h0},
    {1'b0, 1'b0, 4'h2, 1'b1, 4'hA},
    {1'b1, 1'b0, 4'h8, 1'b1, 4'h8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    logic [3:0] held;
    // reset: held address is zero, blanking still wins
    step();
    step();
    chk("R1 reset holds zero", {16'h0, sel}, 32'h1);
    cs = 1'b1;
    #1;
    chk("R8 cs during reset", {16'h0, sel}, 32'h0);
    cs = 1'b0;
    le = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 after reset", {16'h0, sel}, 32'h1);

    foreach (VEC[i]) begin
      le = VEC[i][10];
      cs = VEC[i][9];
      addr = VEC[i][8:5];
      step();
      chk($sformatf("R2/R3/R4 vec %0d", i), {16'h0, sel},
          VEC[i][4] ? (32'h1 << VEC[i][3:0]) : 32'h0);
    end
    held = 4'h8;

    // sweep all addresses for each le/cs pair
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        le = m[1];
        cs = m[0];
        addr = 4'(a);
        step();
        if (le) held = 4'(a);
        chk($sformatf("R5 sweep le=%0d cs=%0d a=%0d", le, cs, a), {16'h0, sel},
            cs ? 32'h0 : (32'h1 << held));
        if (!cs) chk("R5 single line", $countones(sel), 1);
      end
    end

    // load under blanking, then reveal with different pins
    le = 1'b1; cs = 1'b1; addr = 4'hC;
    step();
    chk("R4 blank same cycle as load", {16'h0, sel}, 32'h0);
    le = 1'b0; cs = 1'b0; addr = 4'h1;
    step();
    chk("R4 load under blank kept", {16'h0, sel}, 32'h1 << 12);

    // demux: held address 7, cs carries data
    le = 1'b1; cs = 1'b0; addr = 4'h7;
    step();
    le = 1'b0;
    for (int d = 0; d < 6; d++) begin
      cs = d[0] ^ d[2];
      addr = 4'(d * 5);
      #3;
      chk($sformatf("R6 demux data=%0d", cs), {16'h0, sel}, cs ? 32'h0 : 32'h80);
      step();
    end

    // cascade: bus addresses to page lines
    begin
      logic [15:0] bus [5] = '{16'h0345, 16'h1A00, 16'h1FFF, 16'h0000, 16'h10FF};
      foreach (bus[k]) begin
        pg_le = 1'b1; pg_cs = 1'b0; pg_addr = bus[k][12:8];
        step();
        chk($sformatf("R7 bus %h", bus[k]), pg_sel, 32'h1 << bus[k][12:8]);
      end
    end
    // page bit moves selection while low bits are held
    pg_le = 1'b1; pg_addr = 5'h03;
    step();
    pg_le = 1'b0; pg_addr = 5'h1E;
    #1;
    chk("R7 page bit unlatched", pg_sel, 32'h1 << 19);
    step();
    chk("R7 low bits held", pg_sel, 32'h1 << 19);
    pg_cs = 1'b1;
    #1;
    chk("R4 cascade blank", pg_sel, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule